// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control-address engine of a microprogrammed processor controller. It holds a 6-bit control address register (CAR), reads the microword stored at that address from a 64-entry loadable control store, and presents the word's 19-bit control field to the datapath on the following cycle. The sequencing part of the word is a 3-bit operation and a 6-bit address field. Together with the instruction opcode, two bits of the memory buffer, the accumulator flags and a pending-interrupt input, they choose the next control address.

Fetch microcode starts at address 0 and the interrupt service microcode starts at 0x10. Dispatch on the opcode fills bits 4..1 of the address field, so a field of 0x20 spreads the sixteen opcodes over the even addresses 0x20 to 0x3E. A conditional branch can be paired with a shared landing word to build the two-word skip sequences. The store is filled through a write port, normally while reset is held, and the datapath is outside this block.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `upc` = 0 and `ctrl_word` = 0. After release, fetching begins from address 0.
- R2: Operation 000 (step) sets the next address to CAR + 1, modulo 64, so 0x3F is followed by 0x00.
- R3: Operation 001 (dispatch) sets the next address to the address field bitwise-ORed with the opcode shifted left one place (opcode in bits 4..1). With field 0x20, opcode 0 goes to 0x20, opcode 0xE to 0x3C and opcode 0xF to 0x3E.
- R4: Operation 010 (end of instruction) goes to the address field when `irq_pending` is 1 and to address 0 when it is 0.
- R5: Operation 100 branches to the address field when `mbr[15]` = 0 and `mbr[11]` = 1. In every other case it steps by one.
- R6: Operation 101 branches to the address field when `ac_zero` = 1 and steps by one when it is 0.
- R7: Operation 110 branches to the address field when `ac_neg` = 0 and steps by one when it is 1.
- R8: The unused operations 011 and 111 behave as a step by one. Their address field has no effect.
- R9: `ctrl_word` in each cycle equals the control field of the word at the address `upc` held in the previous cycle.
- R10: A rising edge with `ld_en` = 1 writes `ld_word` into entry `ld_addr`. The word layout is control field in bits 27..9, operation in bits 8..6 and address field in bits 5..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Control store write enable |
| ld_addr | input | 6 | Control store write address |
| ld_word | input | 28 | Microword to write |
| ir_opcode | input | 4 | Instruction opcode for dispatch |
| mbr | input | 16 | Memory buffer contents; bits 15 and 11 test for indirection |
| ac_zero | input | 1 | Accumulator equals zero |
| ac_neg | input | 1 | Accumulator is negative |
| irq_pending | input | 1 | Interrupt request waiting |
| upc | output | 6 | Current control address |
| ctrl_word | output | 19 | Registered control field of the previous address |

## Verification
A wrong next-address choice appears on `upc` at the very next rising edge. The bench therefore compares `upc` against a bench-side model every cycle and catches the first divergence, instead of noticing only after the run has wandered off. A corrupted store entry or a wrong field split appears one cycle later on `ctrl_word`, or as a wrong branch target on `upc`. A reset that does not clear the address shows up as a first fetch that does not come from word 0.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int CTRL_W    = 19;
    localparam int OP_W      = 3;
    localparam int ADDR_W    = 6;
    localparam int OPC_W     = 4;
    localparam int MBR_W     = 16;
    localparam int UW_W      = CTRL_W + OP_W + ADDR_W;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int IND_CLASS = 15;   // must be 0 for an address-bearing opcode
    localparam int IND_FLAG  = 11;   // indirect flag position in the fetched word

    typedef logic [ADDR_W-1:0] uaddr_t;
    typedef logic [CTRL_W-1:0] uctrl_t;

    typedef enum logic [OP_W-1:0] {
        SEQ_STEP     = 3'b000,
        SEQ_DISPATCH = 3'b001,
        SEQ_END      = 3'b010,
        SEQ_SPARE3   = 3'b011,
        SEQ_BR_IND   = 3'b100,
        SEQ_BR_ZERO  = 3'b101,
        SEQ_BR_NNEG  = 3'b110,
        SEQ_SPARE7   = 3'b111
    } seq_op_e;

    typedef enum logic [1:0] {
        NSEL_INC      = 2'd0,
        NSEL_FIELD    = 2'd1,
        NSEL_DISPATCH = 2'd2,
        NSEL_ORIGIN   = 2'd3
    } nsel_e;

    typedef struct packed {
        uctrl_t  ctrl;
        seq_op_e op;
        uaddr_t  nxt;
    } uword_t;

    function automatic uaddr_t step_addr(input uaddr_t cur);
        return cur + uaddr_t'(1);
    endfunction

    function automatic uaddr_t dispatch_addr(input uaddr_t field,
                                             input logic [OPC_W-1:0] opc);
        uaddr_t spread;
        spread = '0;
        spread[OPC_W:1] = opc;
        return field | spread;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  uaddr_t wr_addr,
    input  uword_t wr_data,
    input  uaddr_t rd_addr,
    output uword_t rd_data
);

    uword_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R10

endmodule

// File: rtl/useq_cond.sv
module useq_cond
    import useq_pkg::*;
(
    input  seq_op_e          op,
    input  logic [MBR_W-1:0] mbr,
    input  logic             ac_zero,
    input  logic             ac_neg,
    input  logic             irq,
    output nsel_e            sel
);

    logic ind_hit;

    assign ind_hit = !mbr[IND_CLASS] && mbr[IND_FLAG];

    always_comb begin
        unique case (op)
            SEQ_DISPATCH: sel = NSEL_DISPATCH;
            SEQ_END:      sel = irq     ? NSEL_FIELD : NSEL_ORIGIN;
            SEQ_BR_IND:   sel = ind_hit ? NSEL_FIELD : NSEL_INC;
            SEQ_BR_ZERO:  sel = ac_zero ? NSEL_FIELD : NSEL_INC;
            SEQ_BR_NNEG:  sel = !ac_neg ? NSEL_FIELD : NSEL_INC;
            default:      sel = NSEL_INC;
        endcase
    end

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  uaddr_t           cur,
    input  uaddr_t           field,
    input  logic [OPC_W-1:0] opc,
    input  nsel_e            sel,
    output uaddr_t           nxt
);

    always_comb begin
        unique case (sel)
            NSEL_FIELD:    nxt = field;
            NSEL_DISPATCH: nxt = dispatch_addr(field, opc);
            NSEL_ORIGIN:   nxt = '0;
            default:       nxt = step_addr(cur);
        endcase
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld_en,
    input  logic [ADDR_W-1:0]     ld_addr,
    input  logic [UW_W-1:0]       ld_word,
    input  logic [OPC_W-1:0]      ir_opcode,
    input  logic [MBR_W-1:0]      mbr,
    input  logic                  ac_zero,
    input  logic                  ac_neg,
    input  logic                  irq_pending,
    output logic [ADDR_W-1:0]     upc,
    output logic [CTRL_W-1:0]     ctrl_word
);

    uaddr_t car;
    uaddr_t car_next;
    uword_t word;
    nsel_e  sel;
    uctrl_t ctrl_q;

    useq_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (uword_t'(ld_word)),
        .rd_addr (car),
        .rd_data (word)
    );

    useq_cond u_cond (
        .op      (word.op),
        .mbr     (mbr),
        .ac_zero (ac_zero),
        .ac_neg  (ac_neg),
        .irq     (irq_pending),
        .sel     (sel)
    );

    useq_next u_next (
        .cur   (car),
        .field (word.nxt),
        .opc   (ir_opcode),
        .sel   (sel),
        .nxt   (car_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            car    <= '0;
            ctrl_q <= '0;
        end else begin
            car    <= car_next;
            ctrl_q <= word.ctrl;
        end
    end

    assign upc       = car;
    assign ctrl_word = ctrl_q;

    AST_RESET_ORIGIN: assert property (@(posedge clk)
        rst |=> (upc == '0 && ctrl_word == '0)); // R1

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (word.op inside {SEQ_STEP, SEQ_SPARE3, SEQ_SPARE7})
        |=> upc == $past(upc) + uaddr_t'(1)); // R2 R8

    AST_DISPATCH_SPREAD: assert property (@(posedge clk) disable iff (rst)
        (word.op == SEQ_DISPATCH && word.nxt[OPC_W:1] == '0)
        |=> (upc[OPC_W:1] == $past(ir_opcode)
             && upc[ADDR_W-1] == $past(word.nxt[ADDR_W-1])
             && upc[0] == $past(word.nxt[0]))); // R3

    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (word.op == SEQ_END && !irq_pending) |=> upc == '0); // R4

    AST_END_IRQ: assert property (@(posedge clk) disable iff (rst)
        (word.op == SEQ_END && irq_pending) |=> upc == $past(word.nxt)); // R4

    AST_COND_TARGET: assert property (@(posedge clk) disable iff (rst)
        (word.op inside {SEQ_BR_IND, SEQ_BR_ZERO, SEQ_BR_NNEG})
        |=> (upc == $past(word.nxt) || upc == $past(upc) + uaddr_t'(1))); // R5

    AST_ZERO_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (word.op == SEQ_BR_ZERO && ac_zero) |=> upc == $past(word.nxt)); // R6

    AST_NNEG_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (word.op == SEQ_BR_NNEG && !ac_neg) |=> upc == $past(word.nxt)); // R7

endmodule

// File: tb/tb_useq_top.sv
`timescale 1ns/100ps
module tb_useq_top;
    import useq_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic              ld_en;
    logic [ADDR_W-1:0] ld_addr;
    logic [UW_W-1:0]   ld_word;
    logic [OPC_W-1:0]  ir_opcode;
    logic [MBR_W-1:0]  mbr;
    logic              ac_zero;
    logic              ac_neg;
    logic              irq_pending;
    logic [ADDR_W-1:0] upc;
    logic [CTRL_W-1:0] ctrl_word;

    useq_top dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
        .ir_opcode(ir_opcode), .mbr(mbr), .ac_zero(ac_zero), .ac_neg(ac_neg),
        .irq_pending(irq_pending), .upc(upc), .ctrl_word(ctrl_word)
    );

    logic [UW_W-1:0]   prog [DEPTH];
    logic [ADDR_W-1:0] exp_car;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic [UW_W-1:0] mk(input logic [CTRL_W-1:0] c,
                                           input logic [2:0] o,
                                           input logic [ADDR_W-1:0] f);
        return {c, o, f};
    endfunction

    function automatic logic [ADDR_W-1:0] model_next(
        input logic [UW_W-1:0] w, input logic [ADDR_W-1:0] cur,
        input logic [3:0] o, input logic [15:0] m,
        input logic z, input logic n, input logic i);
        logic [2:0] op;
        logic [ADDR_W-1:0] f, r, inc;
        op  = w[8:6];
        f   = w[5:0];
        inc = cur + 6'd1;
        case (op)
            3'b001: begin r = f; r[4:1] = f[4:1] | o; end
            3'b010: r = i ? f : 6'd0;
            3'b100: r = (!m[15] && m[11]) ? f : inc;
            3'b101: r = z ? f : inc;
            3'b110: r = !n ? f : inc;
            default: r = inc;
        endcase
        return r;
    endfunction

    function automatic string op_tag(input logic [UW_W-1:0] w);
        case (w[8:6])
            3'b000: return "R2";
            3'b001: return "R3";
            3'b010: return "R4";
            3'b100: return "R5";
            3'b101: return "R6";
            3'b110: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [ADDR_W-1:0] a, input logic [UW_W-1:0] w);
        ld_en = 1'b1; ld_addr = a; ld_word = w;
        @(posedge clk); @(negedge clk);
        ld_en = 1'b0;
        prog[a] = w;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R1", 32'(upc), 32'd0);
        chk("R1", 32'(ctrl_word), 32'd0);
        rst = 1'b0;
        exp_car = '0;
    endtask

    task automatic cyc(input logic [3:0] o, input logic [15:0] m,
                       input logic z, input logic n, input logic i);
        logic [UW_W-1:0] w;
        logic [ADDR_W-1:0] nx;
        w = prog[exp_car];
        ir_opcode = o; mbr = m; ac_zero = z; ac_neg = n; irq_pending = i;
        nx = model_next(w, exp_car, o, m, z, n, i);
        @(posedge clk); @(negedge clk);
        chk(op_tag(w), 32'(upc), 32'(nx));
        chk("R9", 32'(ctrl_word), 32'(w[UW_W-1:9]));
        exp_car = nx;
    endtask

    initial begin
        rst = 1'b1; ld_en = 1'b0; ld_addr = '0; ld_word = '0;
        ir_opcode = '0; mbr = '0; ac_zero = 1'b0; ac_neg = 1'b0; irq_pending = 1'b0;
        exp_car = '0;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        chk("R1", 32'(upc), 32'd0);
        chk("R1", 32'(ctrl_word), 32'd0);

        // random program, random inputs
        for (int a = 0; a < DEPTH; a++) load(6'(a), 28'($urandom));
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] m;
            m = 16'($urandom);
            if (($urandom % 4) == 0) m = {1'b0, m[14:12], 1'b1, m[10:0]};
            cyc(4'($urandom), m, ($urandom % 3) == 0, ($urandom % 2) == 0,
                ($urandom % 4) == 0);
        end

        // skip sequences
        rst = 1'b1;
        load(6'h00, mk(19'h1A5A5, 3'b001, 6'h20));
        load(6'h3C, mk(19'h00111, 3'b101, 6'h3F));
        load(6'h3E, mk(19'h00222, 3'b110, 6'h3D));
        load(6'h3F, mk(19'h00333, 3'b010, 6'h10));
        load(6'h3D, mk(19'h00444, 3'b010, 6'h10));
        load(6'h10, mk(19'h00555, 3'b000, 6'h00));
        do_reset();
        cyc(4'hE, 16'h0, 1'b1, 1'b0, 1'b0); chk("R3", 32'(upc), 32'h3C);
        cyc(4'h0, 16'h0, 1'b1, 1'b0, 1'b0); chk("R6", 32'(upc), 32'h3F);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R4", 32'(upc), 32'h00);
        cyc(4'hE, 16'h0, 1'b0, 1'b0, 1'b0);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R6", 32'(upc), 32'h3D);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b1); chk("R4", 32'(upc), 32'h10);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R2", 32'(upc), 32'h11);
        rst = 1'b1;
        do_reset();
        cyc(4'hF, 16'h0, 1'b0, 1'b0, 1'b0); chk("R3", 32'(upc), 32'h3E);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R7", 32'(upc), 32'h3D);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R4", 32'(upc), 32'h00);
        cyc(4'hF, 16'h0, 1'b0, 1'b1, 1'b0);
        cyc(4'h0, 16'h0, 1'b0, 1'b1, 1'b0); chk("R7", 32'(upc), 32'h3F);
        cyc(4'h0, 16'h0, 1'b0, 1'b1, 1'b0); chk("R4", 32'(upc), 32'h00);

        // indirect test, spare codes, wrap, load port
        rst = 1'b1;
        load(6'h20, mk(19'h00666, 3'b100, 6'h3F));
        load(6'h3F, mk(19'h00777, 3'b000, 6'h10));
        load(6'h21, mk(19'h00888, 3'b011, 6'h30));
        load(6'h22, mk(19'h00999, 3'b111, 6'h30));
        load(6'h23, mk(19'h5AA55, 3'b010, 6'h10));
        do_reset();
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R3", 32'(upc), 32'h20);
        cyc(4'h0, 16'h0800, 1'b0, 1'b0, 1'b0); chk("R5", 32'(upc), 32'h3F);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R2", 32'(upc), 32'h00);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0);
        cyc(4'h0, 16'h8800, 1'b0, 1'b0, 1'b0); chk("R5", 32'(upc), 32'h21);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R8", 32'(upc), 32'h22);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R8", 32'(upc), 32'h23);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R4", 32'(upc), 32'h00);
        chk("R10", 32'(ctrl_word), 32'h5AA55);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0);
        cyc(4'h0, 16'h0, 1'b0, 1'b0, 1'b0); chk("R5", 32'(upc), 32'h21);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule